// File: doc/BRIEF.md
# Interrupt Priority and Vector Unit

This unit sits next to a small 8-bit processor core. It gathers interrupt requests from four places: an active-low external pin, a timer, a serial communications interface (SCI) and a serial peripheral interface (SPI). Each peripheral raises several status flags, and each flag has its own enable. The enabled flags of a peripheral are merged into one request, and that request uses the peripheral's single vector. The unit also covers vectoring after reset and for the software interrupt instruction.

The unit never interrupts an instruction part way through. The core pulses `instr_done` as the current instruction completes. At that edge the unit decides whether to take an interrupt and which one. In the next cycle it pulses exactly one of two outputs:
- `vec_take`, together with a request to set the global mask bit and the fetch address of the chosen vector, or
- `fetch_next`, to tell the core to continue with the next instruction.

The vector address is the even (high-byte) address of a two-byte pair. The core reads that byte and the one after it to form the handler address. Requests that lose arbitration are not dropped. Peripheral flags are levels that only the peripheral clears. A falling edge on the external pin is held in a latch until the external interrupt is taken.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is active and afterwards until the first decision, `vec_take`, `fetch_next` and `set_mask` are 0, `vec_src` is 0 and `vec_addr` is 16'h1FFE.
- R2: The first instruction boundary after reset always takes the reset source (code 0, address 16'h1FFE). The mask and all other requests have no effect on it.
- R3: In a cycle that follows a clock edge at which `instr_done` was 0, both `vec_take` and `fetch_next` are 0.
- R4: In the cycle after each boundary, exactly one of `vec_take` and `fetch_next` is 1.
- R5: `swi_exec` at a boundary takes the software interrupt (code 1, address 16'h1FFC) whatever the state of `i_mask`. It also wins over every pending hardware request.
- R6: A hardware request is taken only when `i_mask` is 0 and its enable is set. If no request qualifies, the unit pulses `fetch_next`.
- R7: Hardware priority runs external pin (code 2, 16'h1FFA) > timer (code 3, 16'h1FF8) > SCI (code 4, 16'h1FF6) > SPI (code 5, 16'h1FF4).
- R8: The timer request is the OR of `tmr_flags & tmr_en` (bit 0 input capture, bit 1 output compare, bit 2 overflow). The SCI request is the OR of `sci_flags & sci_en` (bits: transmit empty, transmit complete, receive full, idle line, overrun). The SPI request is the OR of `spi_flags & spi_en` (bit 0 transfer complete, bit 1 mode fault). A flag whose enable is 0 has no effect.
- R9: A falling edge on `irq_pin_n` passes through two synchroniser flops and is then latched. It can be taken at any boundary from the fourth clock edge after the fall onward. The latch stays set while it is not taken, for example while `irq_en` or `i_mask` blocks it. It is cleared only when the external interrupt is taken.
- R10: A lower-priority request that loses at a boundary stays pending. It is taken at a later boundary once it is the highest qualifying request.
- R11: Every take is accompanied by `set_mask` in the same cycle. On a take, `vec_addr` equals 16'h1FFE minus twice `vec_src`.
- R12: `vec_addr` changes only in a cycle in which `vec_take` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction completes at this edge |
| swi_exec | input | 1 | The completing instruction is a software interrupt |
| i_mask | input | 1 | Global interrupt mask bit from the core |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| irq_en | input | 1 | Enable for the external interrupt |
| tmr_flags | input | TMR_N | Timer status flags |
| tmr_en | input | TMR_N | Per-flag timer enables |
| sci_flags | input | SCI_N | SCI status flags |
| sci_en | input | SCI_N | Per-flag SCI enables |
| spi_flags | input | SPI_N | SPI status flags |
| spi_en | input | SPI_N | Per-flag SPI enables |
| vec_take | output | 1 | One-cycle pulse: an interrupt was accepted |
| fetch_next | output | 1 | One-cycle pulse: no interrupt, fetch the next instruction |
| set_mask | output | 1 | One-cycle request to set the global mask bit |
| vec_src | output | 3 | Code of the accepted source (0 reset to 5 SPI) |
| vec_addr | output | 16 | High-byte address of the accepted vector pair |

## Verification
The bench builds the unit with its defaults: three timer flags, five SCI flags, two SPI flags, a two-stage synchroniser and a top vector of 16'h1FFE. With these values every flag of every group can be driven on its own, and a random pattern can hit every source code. The seeded random phase mixes pin edges, masks and enables, so that ties between several groups and requests held back by the mask occur many times. The directed cases cover the reset vector, the software interrupt under the mask, and a pin edge that stays pending while its enable is off.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_RESET = 3'd0,
    SRC_SWI   = 3'd1,
    SRC_PIN   = 3'd2,
    SRC_TMR   = 3'd3,
    SRC_SCI   = 3'd4,
    SRC_SPI   = 3'd5
  } src_e;

  // Vector pairs descend by two bytes from the top pair in priority order.
  function automatic logic [15:0] vec_of(input logic [15:0] top,
                                         input logic [SRC_W-1:0] code);
    return top - {12'd0, code, 1'b0};
  endfunction
endpackage

// File: rtl/irqv_pin_latch.sv
module irqv_pin_latch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr,
  output logic fall,
  output logic pending
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

  // A fresh edge wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= 1'b0;
    else if (fall) pending <= 1'b1;
    else if (clr)  pending <= 1'b0;
  end
endmodule

// File: rtl/irqv_group.sv
module irqv_group #(
  parameter int N = 3
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] en,
  output logic         req
);
  logic [N-1:0] hit;
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_hit
      assign hit[g] = flags[g] & en[g];
    end
  endgenerate
  assign req = |hit;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     req,
  output logic             valid,
  output logic [SRC_W-1:0] sel
);
  // Index 0 is the highest priority.
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) sel = i[SRC_W-1:0];
    end
  end
  assign valid = |req;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int          TMR_N   = 3,
  parameter int          SCI_N   = 5,
  parameter int          SPI_N   = 2,
  parameter int          SYNC_N  = 2,
  parameter logic [15:0] VEC_TOP = 16'h1FFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic             swi_exec,
  input  logic             i_mask,
  input  logic             irq_pin_n,
  input  logic             irq_en,
  input  logic [TMR_N-1:0] tmr_flags,
  input  logic [TMR_N-1:0] tmr_en,
  input  logic [SCI_N-1:0] sci_flags,
  input  logic [SCI_N-1:0] sci_en,
  input  logic [SPI_N-1:0] spi_flags,
  input  logic [SPI_N-1:0] spi_en,
  output logic             vec_take,
  output logic             fetch_next,
  output logic             set_mask,
  output logic [2:0]       vec_src,
  output logic [15:0]      vec_addr
);
  logic             reset_pend;
  logic             irq_fall;
  logic             irq_pending;
  logic             irq_clr;
  logic             tmr_req, sci_req, spi_req;
  logic             hw_open;
  logic [NUM_SRC-1:0] req_vec;
  logic             win_valid;
  logic [SRC_W-1:0] win_sel;
  logic             decide_take;

  irqv_pin_latch #(.STAGES(SYNC_N)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n), .clr(irq_clr),
    .fall(irq_fall), .pending(irq_pending)
  );

  irqv_group #(.N(TMR_N)) u_tmr (.flags(tmr_flags), .en(tmr_en), .req(tmr_req));
  irqv_group #(.N(SCI_N)) u_sci (.flags(sci_flags), .en(sci_en), .req(sci_req));
  irqv_group #(.N(SPI_N)) u_spi (.flags(spi_flags), .en(spi_en), .req(spi_req));

  assign hw_open = ~i_mask;

  always_comb begin
    req_vec          = '0;
    req_vec[SRC_RESET] = reset_pend;
    req_vec[SRC_SWI]   = swi_exec;
    req_vec[SRC_PIN]   = hw_open & irq_en & irq_pending;
    req_vec[SRC_TMR]   = hw_open & tmr_req;
    req_vec[SRC_SCI]   = hw_open & sci_req;
    req_vec[SRC_SPI]   = hw_open & spi_req;
  end

  irqv_arbiter #(.N(NUM_SRC)) u_arb (
    .req(req_vec), .valid(win_valid), .sel(win_sel)
  );

  assign decide_take = instr_done & win_valid;
  assign irq_clr     = decide_take & (win_sel == SRC_PIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_pend <= 1'b1;
      vec_take   <= 1'b0;
      fetch_next <= 1'b0;
      set_mask   <= 1'b0;
      vec_src    <= SRC_RESET;
      vec_addr   <= VEC_TOP;
    end else begin
      vec_take   <= decide_take;
      set_mask   <= decide_take;
      fetch_next <= instr_done & ~win_valid;
      if (instr_done) reset_pend <= 1'b0;
      if (decide_take) begin
        vec_src  <= win_sel;
        vec_addr <= vec_of(VEC_TOP, win_sel);
      end
    end
  end
endmodule

// File: rtl/irqv_checks.sv
module irqv_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_done,
  input logic        swi_exec,
  input logic        i_mask,
  input logic        vec_take,
  input logic        fetch_next,
  input logic        set_mask,
  input logic [2:0]  vec_src,
  input logic [15:0] vec_addr,
  input logic        irq_fall,
  input logic        irq_pending
);
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> (!vec_take && !fetch_next));

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (vec_take ^ fetch_next));

  assert_swi_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && swi_exec) |=> (vec_take && vec_src <= 3'd1));

  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && i_mask && !swi_exec) |=> (!vec_take || vec_src == 3'd0));

  assert_edge_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |=> irq_pending);

  assert_mask_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take == set_mask);

  assert_vec_form_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> (vec_addr[15:4] == 12'h1FF && !vec_addr[0] && vec_src <= 3'd5));

  assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_take |-> $stable(vec_addr));
endmodule

bind irq_vector_unit irqv_checks u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .swi_exec(swi_exec),
  .i_mask(i_mask), .vec_take(vec_take), .fetch_next(fetch_next),
  .set_mask(set_mask), .vec_src(vec_src), .vec_addr(vec_addr),
  .irq_fall(irq_fall), .irq_pending(irq_pending)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 0, swi_exec = 0, i_mask = 0, irq_pin_n = 1, irq_en = 0;
  logic [2:0] tmr_flags = 0, tmr_en = 0;
  logic [4:0] sci_flags = 0, sci_en = 0;
  logic [1:0] spi_flags = 0, spi_en = 0;
  logic vec_take, fetch_next, set_mask;
  logic [2:0] vec_src;
  logic [15:0] vec_addr;

  int checks = 0, failures = 0;
  bit model_pin = 0;
  bit model_rst = 1;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .swi_exec(swi_exec),
    .i_mask(i_mask), .irq_pin_n(irq_pin_n), .irq_en(irq_en),
    .tmr_flags(tmr_flags), .tmr_en(tmr_en), .sci_flags(sci_flags),
    .sci_en(sci_en), .spi_flags(spi_flags), .spi_en(spi_en),
    .vec_take(vec_take), .fetch_next(fetch_next), .set_mask(set_mask),
    .vec_src(vec_src), .vec_addr(vec_addr)
  );

  function automatic logic [15:0] exp_addr(input logic [2:0] c);
    case (c)
      3'd0: return 16'h1FFE;
      3'd1: return 16'h1FFC;
      3'd2: return 16'h1FFA;
      3'd3: return 16'h1FF8;
      3'd4: return 16'h1FF6;
      default: return 16'h1FF4;
    endcase
  endfunction

  // 7 means no take.
  function automatic logic [2:0] exp_code();
    if (model_rst) return 3'd0;
    if (swi_exec) return 3'd1;
    if (i_mask) return 3'd7;
    if (model_pin && irq_en) return 3'd2;
    if ((tmr_flags & tmr_en) != 0) return 3'd3;
    if ((sci_flags & sci_en) != 0) return 3'd4;
    if ((spi_flags & spi_en) != 0) return 3'd5;
    return 3'd7;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin_pulse();
    irq_pin_n = 1'b0;
    wait_neg(4);
    model_pin = 1;
    irq_pin_n = 1'b1;
    wait_neg(4);
  endtask

  task automatic boundary(input string req);
    logic [2:0] e;
    e = exp_code();
    instr_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_done = 1'b0;
    if (e == 3'd7) begin
      check(req, {29'd0, vec_take, fetch_next, set_mask}, 32'd2);
    end else begin
      check(req, {29'd0, vec_take, fetch_next, set_mask}, 32'd5);
      check(req, {29'd0, vec_src}, {29'd0, e});
      check(req, {16'd0, vec_addr}, {16'd0, exp_addr(e)});
      if (e == 3'd2) model_pin = 0;
    end
    model_rst = 0;
  endtask

  task automatic clear_all();
    swi_exec = 0; i_mask = 0; irq_en = 0;
    tmr_flags = 0; tmr_en = 0; sci_flags = 0; sci_en = 0;
    spi_flags = 0; spi_en = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed;
    logic [15:0] held;
    seed = 32'd12345;
    void'($urandom(seed));
    wait_neg(3);
    // R1: reset state
    check("R1", {29'd0, vec_take, fetch_next, set_mask}, 32'd0);
    check("R1", {13'd0, vec_src, vec_addr}, {13'd0, 3'd0, 16'h1FFE});
    rst_n = 1'b1;
    wait_neg(2);
    check("R1 R3", {29'd0, vec_take, fetch_next, set_mask}, 32'd0);

    // R2: reset vector wins despite mask and other requests
    swi_exec = 1; i_mask = 1; tmr_flags = 3'b111; tmr_en = 3'b111;
    boundary("R2");
    clear_all();
    wait_neg(1);
    check("R3", {30'd0, vec_take, fetch_next}, 32'd0);

    boundary("R6 R4 idle");
    // R5: software interrupt under the mask and over hardware
    i_mask = 1; swi_exec = 1;
    boundary("R5 masked");
    i_mask = 0; tmr_flags = 3'b001; tmr_en = 3'b001;
    boundary("R5 over timer");
    swi_exec = 0;
    held = vec_addr;
    wait_neg(2);
    check("R12", {16'd0, vec_addr}, {16'd0, held});
    // R6: mask blocks, disabled flag ignored
    i_mask = 1;
    boundary("R6 masked");
    i_mask = 0; tmr_en = 3'b110;
    boundary("R8 enable off");
    // R8: each flag on its own
    clear_all();
    for (int b = 0; b < 3; b++) begin
      tmr_flags = 3'(1 << b); tmr_en = 3'(1 << b);
      boundary("R8 timer");
    end
    clear_all();
    for (int b = 0; b < 5; b++) begin
      sci_flags = 5'(1 << b); sci_en = 5'(1 << b);
      boundary("R8 sci");
    end
    clear_all();
    for (int b = 0; b < 2; b++) begin
      spi_flags = 2'(1 << b); spi_en = 2'(1 << b);
      boundary("R8 spi");
    end
    // R7 and R10: priority and held lower requests
    irq_en = 1; tmr_flags = 3'b100; tmr_en = 3'b100;
    sci_flags = 5'b00001; sci_en = 5'b00001;
    pin_pulse();
    boundary("R7 pin first");
    boundary("R10 timer next");
    tmr_flags = 0;
    boundary("R10 sci next");
    sci_flags = 0;
    boundary("R7 spi last");
    clear_all();
    // R9: pending while disabled, taken when enabled, cleared after
    pin_pulse();
    boundary("R9 disabled");
    i_mask = 1; irq_en = 1;
    boundary("R9 masked");
    i_mask = 0;
    boundary("R9 taken");
    boundary("R9 cleared");
    clear_all();

    // Random phase
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      swi_exec  = (r[3:0] == 4'd0);
      i_mask    = (r[6:4] == 3'd0);
      irq_en    = r[7];
      tmr_flags = r[10:8];  tmr_en = r[13:11];
      sci_flags = r[18:14]; sci_en = r[23:19];
      spi_flags = r[25:24]; spi_en = r[27:26];
      if (r[31:29] == 3'd0) pin_pulse();
      boundary("R7 R10 random");
      if (r[28]) begin
        wait_neg(1);
        check("R3 random", {30'd0, vec_take, fetch_next}, 32'd0);
      end
    end
    finished = 1;
    finish_run();
  end
endmodule